// File: doc/BRIEF.md
# Two-Wire Serial Target Controller with Host Registers

This block answers as a target (slave) on a two-wire serial bus and hands every completed byte to a host processor through three small registers: an own-address register, a data register and a control/status register carrying an event flag. The bus clock and data lines are sampled through synchronizer chains, and the block detects START and STOP conditions on the system clock. After a START it collects the eight-bit address byte and compares its upper seven bits with the programmed address. If general-call recognition is switched on, the all-zero address also counts as a match.

On a match the block acknowledges the address and then raises the event flag, which also drives the interrupt output. While the flag is set it holds the clock line low, so the host has time to read the received byte or load the next byte to send. The host clears the flag by writing a one to it. This releases the clock, and the block moves the next data byte in the direction given by the read/write bit of the address. It generates and checks acknowledges by itself. Both bus lines are driven only as active-low output enables.

The data register always ends up holding the last byte seen on the bus. This includes bytes the block sends, because it samples the line level while it shifts a byte out. The host can write the data register only while the flag is set, and bus traffic cannot change it during that time.

Top module: `i2cs_top`

## Requirements
- R1: After reset the own-address register reads 0xFE, the data register reads 0xFF, the control register reads 0x00 and both bus enables are low.
- R2: An address byte whose bits 7:1 equal own-address bits 7:1 is acknowledged (SDA pulled low during the ninth clock). The flag (control bit 0, also the `irq` output) then sets on the following SCL fall, and the data register holds the address byte.
- R3: An address byte that does not match is not acknowledged and does not set the flag. The data register still takes that byte.
- R4: Address 0x00 is recognized only when own-address bit 0 is 1. When bit 0 is 0, that address is not acknowledged and sets no flag.
- R5: With address bit 0 = 0 (write), every following data byte is acknowledged, stored in the data register, and sets the flag after its acknowledge clock.
- R6: With address bit 0 = 1 (read), the byte in the data register when the flag is cleared goes out MSB first. SDA changes only while SCL is low, and afterwards the data register holds the byte sampled from the bus. Control bit 1 reads 1 in this direction.
- R7: A NACK from the master after a transmitted byte ends the transfer. No flag is set and SDA is released.
- R8: While the flag is set the block pulls SCL low. Writing the control register with bit 0 = 1 clears the flag and releases SCL.
- R9: Host writes to the data register take effect only while the flag is set. At other times they have no effect, and while the flag is set the data register changes only through host writes.
- R10: A STOP (SDA rising while SCL is high) at any point, including in the middle of a byte, releases both lines and returns the block to waiting for a START. The next addressed transfer is then handled normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host write strobe |
| host_sel | input | 2 | Register select: 0 own address, 1 data, 2 control/status |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Registered read data of the selected register |
| irq | output | 1 | Event flag / interrupt request |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| scl_oe | output | 1 | Pull bus clock low when 1 |
| sda_oe | output | 1 | Pull bus data low when 1 |

## Verification
The bench builds the block with three synchronizer stages instead of the default two. This widens the delay between a line moving and the engine reacting to it, and the bench master's clock-stretch-aware timing must absorb that delay. A bus half-period of ten system clocks keeps SCL low long enough after each edge for the later SDA changes, the late acknowledge drive and the first transmit bit released from the stretch. The test covers both general-call settings, a NACK-terminated read, and a STOP in the middle of an address.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W);

  localparam logic [1:0] SEL_OWN  = 2'd0;
  localparam logic [1:0] SEL_DATA = 2'd1;
  localparam logic [1:0] SEL_CTRL = 2'd2;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_END,
    ST_ACK_OUT,
    ST_HOLD,
    ST_RX,
    ST_RX_END,
    ST_TX,
    ST_TX_END,
    ST_TX_ACK
  } eng_state_t;
endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_lane
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '1;
      else     chain <= {chain[STAGES-2:0], din[g]};
    end
    assign dout[g] = chain[STAGES-1];
  end
endmodule

// File: rtl/i2cs_cond.sv
module i2cs_cond (
  input  logic clk,
  input  logic rst,
  input  logic scl_s,
  input  logic sda_s,
  output logic start_det,
  output logic stop_det,
  output logic scl_rise,
  output logic scl_fall
);
  logic scl_p, sda_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_s;
      sda_p <= sda_s;
    end
  end

  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
endmodule

// File: rtl/i2cs_engine.sv
module i2cs_engine
  import i2cs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              sda_s,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic [BYTE_W-1:0] own_addr,
  input  logic              host_dwr,
  input  logic [BYTE_W-1:0] host_wdata,
  input  logic              flag_clr,
  output logic [BYTE_W-1:0] data_q,
  output logic              flag_q,
  output logic              dir_q,
  output logic              scl_oe,
  output logic              sda_oe
);
  eng_state_t        state;
  logic [CNT_W-1:0]  bitcnt;
  logic [BYTE_W-1:0] sh, tx_byte;
  logic              ack_q;
  logic [BYTE_W-1:0] sh_next;
  logic              addr_hit;

  assign sh_next  = {sh[BYTE_W-2:0], sda_s};
  assign addr_hit = (sh[BYTE_W-1:1] == own_addr[BYTE_W-1:1]) ||
                    ((sh[BYTE_W-1:1] == '0) && own_addr[0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      bitcnt  <= '0;
      sh      <= '0;
      tx_byte <= '1;
      data_q  <= '1;
      flag_q  <= 1'b0;
      dir_q   <= 1'b0;
      ack_q   <= 1'b0;
      scl_oe  <= 1'b0;
      sda_oe  <= 1'b0;
    end else begin
      if (host_dwr && flag_q) data_q <= host_wdata;
      if (flag_clr)           flag_q <= 1'b0;

      if (stop_det) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
        scl_oe <= 1'b0;
      end else if (start_det) begin
        state  <= ST_ADDR;
        bitcnt <= '0;
        sda_oe <= 1'b0;
        scl_oe <= 1'b0;
      end else begin
        case (state)
          ST_ADDR, ST_RX, ST_TX: begin
            if (scl_rise) begin
              sh <= sh_next;
              if (bitcnt == CNT_W'(BYTE_W - 1)) begin
                if (!flag_q) data_q <= sh_next;
                if (state == ST_ADDR) begin
                  dir_q <= sda_s;
                  state <= ST_ADDR_END;
                end else if (state == ST_RX) begin
                  state <= ST_RX_END;
                end else begin
                  state <= ST_TX_END;
                end
              end else begin
                bitcnt <= bitcnt + 1'b1;
              end
            end
            if (scl_fall && state == ST_TX)
              sda_oe <= ~tx_byte[CNT_W'(BYTE_W - 1) - bitcnt];
          end
          ST_ADDR_END: if (scl_fall) begin
            bitcnt <= '0;
            if (addr_hit) begin
              sda_oe <= 1'b1;
              state  <= ST_ACK_OUT;
            end else begin
              state  <= ST_IDLE;
            end
          end
          ST_RX_END: if (scl_fall) begin
            sda_oe <= 1'b1;
            state  <= ST_ACK_OUT;
          end
          ST_ACK_OUT: if (scl_fall) begin
            sda_oe <= 1'b0;
            scl_oe <= 1'b1;
            flag_q <= 1'b1;
            state  <= ST_HOLD;
          end
          ST_HOLD: if (flag_clr) begin
            scl_oe <= 1'b0;
            bitcnt <= '0;
            if (dir_q) begin
              tx_byte <= data_q;
              sda_oe  <= ~data_q[BYTE_W-1];
              state   <= ST_TX;
            end else begin
              state   <= ST_RX;
            end
          end
          ST_TX_END: if (scl_fall) begin
            sda_oe <= 1'b0;
            state  <= ST_TX_ACK;
          end
          ST_TX_ACK: begin
            if (scl_rise) ack_q <= ~sda_s;
            if (scl_fall) begin
              if (ack_q) begin
                scl_oe <= 1'b1;
                flag_q <= 1'b1;
                state  <= ST_HOLD;
              end else begin
                state  <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2cs_top.sv
module i2cs_top
  import i2cs_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int SEL_W       = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_we,
  input  logic [SEL_W-1:0]  host_sel,
  input  logic [BYTE_W-1:0] host_wdata,
  output logic [BYTE_W-1:0] host_rdata,
  output logic              irq,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe,
  output logic              sda_oe
);
  logic [1:0]        lines_s;
  logic              scl_s, sda_s;
  logic              start_det, stop_det, scl_rise, scl_fall;
  logic [BYTE_W-1:0] own_q, data_q;
  logic              flag_q, dir_q;
  logic              host_dwr, flag_clr;

  i2cs_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din({scl_i, sda_i}), .dout(lines_s)
  );
  assign scl_s = lines_s[1];
  assign sda_s = lines_s[0];

  i2cs_cond u_cond (
    .clk(clk), .rst(rst), .scl_s(scl_s), .sda_s(sda_s),
    .start_det(start_det), .stop_det(stop_det),
    .scl_rise(scl_rise), .scl_fall(scl_fall)
  );

  assign host_dwr = host_we && (host_sel == SEL_W'(SEL_DATA));
  assign flag_clr = host_we && (host_sel == SEL_W'(SEL_CTRL)) && host_wdata[0];

  i2cs_engine u_eng (
    .clk(clk), .rst(rst), .sda_s(sda_s),
    .start_det(start_det), .stop_det(stop_det),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .own_addr(own_q), .host_dwr(host_dwr), .host_wdata(host_wdata),
    .flag_clr(flag_clr), .data_q(data_q), .flag_q(flag_q), .dir_q(dir_q),
    .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      own_q      <= 8'hFE;
      host_rdata <= '0;
    end else begin
      if (host_we && host_sel == SEL_W'(SEL_OWN)) own_q <= host_wdata;
      case (host_sel)
        SEL_W'(SEL_OWN):  host_rdata <= own_q;
        SEL_W'(SEL_DATA): host_rdata <= data_q;
        SEL_W'(SEL_CTRL): host_rdata <= {{(BYTE_W-2){1'b0}}, dir_q, flag_q};
        default:          host_rdata <= '0;
      endcase
    end
  end

  assign irq = flag_q;
endmodule

// File: rtl/i2cs_checker.sv
module i2cs_checker (
  input logic       clk,
  input logic       rst,
  input logic [7:0] own_q,
  input logic [7:0] data_q,
  input logic       flag_q,
  input logic       host_dwr,
  input logic       scl_s,
  input logic       scl_fall,
  input logic       stop_det,
  input logic       scl_oe,
  input logic       sda_oe
);
  a_r1_reset_values: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (own_q == 8'hFE && data_q == 8'hFF && !flag_q && !scl_oe && !sda_oe));

  a_r2_flag_on_scl_fall: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_q) |-> $past(scl_fall));

  a_r6_sda_moves_scl_low: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> $past(!scl_s));

  a_r8_stretch_needs_flag: assert property (@(posedge clk) disable iff (rst)
    scl_oe |-> flag_q);

  a_r9_data_frozen: assert property (@(posedge clk) disable iff (rst)
    (flag_q && $past(flag_q) && !$past(host_dwr)) |-> $stable(data_q));

  a_r10_stop_releases: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> (!scl_oe && !sda_oe));
endmodule

bind i2cs_top i2cs_checker u_chk (
  .clk(clk), .rst(rst), .own_q(own_q), .data_q(data_q), .flag_q(flag_q),
  .host_dwr(host_dwr), .scl_s(scl_s), .scl_fall(scl_fall),
  .stop_det(stop_det), .scl_oe(scl_oe), .sda_oe(sda_oe)
);

// File: tb/tb_i2cs_top.sv
module tb_i2cs_top;
  localparam int HALF = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       host_we = 1'b0;
  logic [1:0] host_sel = 2'd0;
  logic [7:0] host_wdata = 8'h00;
  logic [7:0] host_rdata;
  logic       irq, scl_oe, sda_oe;
  logic       m_scl_low = 1'b0, m_sda_low = 1'b0;
  logic       scl_w, sda_w;

  assign scl_w = !(m_scl_low || scl_oe);
  assign sda_w = !(m_sda_low || sda_oe);

  always #5 clk = ~clk;

  i2cs_top #(.SYNC_STAGES(3)) dut (
    .clk(clk), .rst(rst), .host_we(host_we), .host_sel(host_sel),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .irq(irq),
    .scl_i(scl_w), .sda_i(sda_w), .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  typedef struct { string tag; logic [7:0] val; } item_t;
  item_t      exp_q[$];
  logic [7:0] tx_q[$];
  int n_checks = 0, n_errors = 0, irq_cnt = 0;
  logic auto_mode = 1'b1;
  bit   done = 1'b0;

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_errors++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic finish_sim();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  endtask

  task automatic host_wr(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    host_we = 1'b1; host_sel = sel; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic host_rd(input logic [1:0] sel, output logic [7:0] d);
    @(negedge clk);
    host_sel = sel;
    @(negedge clk);
    d = host_rdata;
  endtask

  task automatic wait_h(); repeat (HALF) @(negedge clk); endtask
  task automatic wait_scl_high(); while (!scl_w) @(negedge clk); endtask

  task automatic m_wbit(input logic v);
    m_sda_low = !v; wait_h();
    m_scl_low = 1'b0; wait_scl_high(); wait_h();
    m_scl_low = 1'b1; wait_h();
  endtask

  task automatic m_rbit(output logic v);
    m_sda_low = 1'b0; wait_h();
    m_scl_low = 1'b0; wait_scl_high();
    repeat (HALF/2) @(negedge clk);
    v = sda_w;
    repeat (HALF/2) @(negedge clk);
    m_scl_low = 1'b1; wait_h();
  endtask

  task automatic m_start();
    m_sda_low = 1'b0; wait_h();
    m_scl_low = 1'b0; wait_scl_high(); wait_h();
    m_sda_low = 1'b1; wait_h();
    m_scl_low = 1'b1; wait_h();
  endtask

  task automatic m_stop();
    m_sda_low = 1'b1; wait_h();
    m_scl_low = 1'b0; wait_scl_high(); wait_h();
    m_sda_low = 1'b0; wait_h();
  endtask

  task automatic m_wbyte(input logic [7:0] b, output logic acked);
    logic a;
    for (int i = 7; i >= 0; i--) m_wbit(b[i]);
    m_rbit(a);
    acked = !a;
  endtask

  task automatic m_rbyte(output logic [7:0] b, input logic send_ack);
    logic v;
    for (int i = 7; i >= 0; i--) begin m_rbit(v); b[i] = v; end
    m_wbit(!send_ack);
  endtask

  task automatic expect_item(input string tag, input logic [7:0] v);
    item_t it;
    it.tag = tag; it.val = v;
    exp_q.push_back(it);
  endtask

  // Monitor: acts as host software, pops expected data on each flag event
  initial begin
    logic [7:0] v, c;
    item_t it;
    forever begin
      @(posedge irq);
      irq_cnt++;
      if (auto_mode) begin
        repeat (2) @(negedge clk);
        host_rd(2'd1, v);
        if (exp_q.size() == 0) chk("scoreboard unexpected flag", v, 8'hxx);
        else begin
          it = exp_q.pop_front();
          chk(it.tag, v, it.val);
        end
        host_rd(2'd2, c);
        if (c[1]) host_wr(2'd1, (tx_q.size() > 0) ? tx_q.pop_front() : 8'hFF);
        host_wr(2'd2, 8'h01);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_sim();
  end

  initial begin
    logic [7:0] r;
    logic       ack;
    int         base;

    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // R1 reset state
    host_rd(2'd0, r); chk("R1 own reset", r, 8'hFE);
    host_rd(2'd1, r); chk("R1 data reset", r, 8'hFF);
    host_rd(2'd2, r); chk("R1 ctrl reset", r, 8'h00);
    chk("R1 bus released", {6'd0, scl_oe, sda_oe}, 8'h00);

    // R9 data write ignored while flag clear
    host_wr(2'd1, 8'h12);
    host_rd(2'd1, r); chk("R9 write ignored flag clear", r, 8'hFF);

    host_wr(2'd0, 8'hB4);

    // R2 + R5 addressed write with two data bytes
    expect_item("R2 data holds address", 8'hB4);
    expect_item("R5 first byte", 8'h3C);
    expect_item("R5 second byte", 8'hA5);
    m_start();
    m_wbyte(8'hB4, ack); chk("R2 address ack", {7'd0, ack}, 8'h01);
    m_wbyte(8'h3C, ack); chk("R5 byte1 ack", {7'd0, ack}, 8'h01);
    m_wbyte(8'hA5, ack); chk("R5 byte2 ack", {7'd0, ack}, 8'h01);
    m_stop();
    repeat (20) @(negedge clk);
    chk("R2 scoreboard drained", 8'(exp_q.size()), 8'd0);
    chk("R10 lines released after stop", {6'd0, scl_oe, sda_oe}, 8'h00);

    // R3 mismatching address
    base = irq_cnt;
    m_start();
    m_wbyte(8'h44, ack); chk("R3 no ack", {7'd0, ack}, 8'h00);
    m_stop();
    repeat (20) @(negedge clk);
    chk("R3 no flag event", 8'(irq_cnt - base), 8'd0);
    host_rd(2'd1, r); chk("R3 data mirrors bus", r, 8'h44);

    // R4 general call disabled then enabled
    m_start();
    m_wbyte(8'h00, ack); chk("R4 gc disabled no ack", {7'd0, ack}, 8'h00);
    m_stop();
    repeat (20) @(negedge clk);
    chk("R4 gc disabled no flag", 8'(irq_cnt - base), 8'd0);
    host_wr(2'd0, 8'hB5);
    expect_item("R4 gc data", 8'h00);
    m_start();
    m_wbyte(8'h00, ack); chk("R4 gc enabled ack", {7'd0, ack}, 8'h01);
    repeat (60) @(negedge clk);
    m_stop();
    repeat (20) @(negedge clk);
    chk("R4 gc flag event", 8'(irq_cnt - base), 8'd1);

    // R6 + R7 read transfer ending with NACK
    expect_item("R6 data holds read address", 8'hB5);
    expect_item("R6 data mirrors sent byte", 8'hC3);
    tx_q.push_back(8'hC3);
    tx_q.push_back(8'h7E);
    m_start();
    m_wbyte(8'hB5, ack); chk("R6 read address ack", {7'd0, ack}, 8'h01);
    m_rbyte(r, 1'b1); chk("R6 first sent byte", r, 8'hC3);
    m_rbyte(r, 1'b0); chk("R6 second sent byte", r, 8'h7E);
    base = irq_cnt;
    repeat (40) @(negedge clk);
    chk("R7 no flag after nack", 8'(irq_cnt - base), 8'd0);
    host_rd(2'd2, r); chk("R7 flag clear", r & 8'h01, 8'h00);
    chk("R6 direction bit", r & 8'h02, 8'h02);
    chk("R7 sda released", {7'd0, sda_oe}, 8'h00);
    m_stop();
    repeat (20) @(negedge clk);
    host_rd(2'd1, r); chk("R6 data after nack mirrors bus", r, 8'h7E);

    // R8 + R9 manual host handling
    auto_mode = 1'b0;
    m_start();
    m_wbyte(8'hB4, ack); chk("R8 address ack", {7'd0, ack}, 8'h01);
    repeat (30) @(negedge clk);
    chk("R8 scl stretched", {7'd0, scl_oe}, 8'h01);
    host_rd(2'd2, r); chk("R8 flag set", r, 8'h01);
    chk("R8 irq output", {7'd0, irq}, 8'h01);
    host_wr(2'd1, 8'h99);
    host_rd(2'd1, r); chk("R9 write accepted flag set", r, 8'h99);
    repeat (30) @(negedge clk);
    host_rd(2'd1, r); chk("R9 data frozen while flag", r, 8'h99);
    host_wr(2'd2, 8'h01);
    @(negedge clk);
    chk("R8 scl released on clear", {7'd0, scl_oe}, 8'h00);
    host_rd(2'd2, r); chk("R8 flag cleared", r, 8'h00);
    m_wbyte(8'h55, ack); chk("R5 manual byte ack", {7'd0, ack}, 8'h01);
    repeat (30) @(negedge clk);
    host_rd(2'd1, r); chk("R5 manual byte stored", r, 8'h55);
    host_wr(2'd2, 8'h01);
    m_stop();
    repeat (20) @(negedge clk);
    auto_mode = 1'b1;

    // R10 STOP in the middle of an address
    m_start();
    m_wbit(1'b1); m_wbit(1'b0); m_wbit(1'b1); m_wbit(1'b1);
    m_stop();
    repeat (20) @(negedge clk);
    chk("R10 released after mid-byte stop", {6'd0, scl_oe, sda_oe}, 8'h00);
    expect_item("R10 transfer after abort", 8'hB4);
    m_start();
    m_wbyte(8'hB4, ack); chk("R10 address ack after abort", {7'd0, ack}, 8'h01);
    m_stop();
    repeat (20) @(negedge clk);
    chk("R10 scoreboard drained", 8'(exp_q.size()), 8'd0);

    finish_sim();
  end
endmodule